// File: doc/BRIEF.md
# Indirect Inner-Register Access Window

This block places a small bank of host-visible window registers in front of a private 64-entry register space, such as the configuration registers of a delay-locked loop. The host cannot address the inner registers directly. It writes an inner address and a direction into a control window. For a write it also loads a data window. It then raises a start bit. The block performs exactly one inner access and, for a read, leaves the result in a read-data window for the host to fetch.

The inner space is guarded. After reset it is locked, and any inner write aimed at an address other than 0 is discarded. Writing the key 0xA5000000 to inner address 0 opens the space. Writing any other value there closes it again. Inner address 0x26 is a read-only status word that carries a calibration code taken from an input port.

Each access takes `ACCESS_LAT` clock edges from the start edge to completion; the default is 2. During that time the busy output is high. The address, direction and data used by the access are captured on the start edge.

Top module: `dllw_port`

## Requirements
- R1: The control window (host offset 0) keeps only the inner address in bits [5:0] and the direction in bit 8, where 1 means read and 0 means write. All other bits read back as 0.
- R2: An inner access starts only on a 0-to-1 change of bit 0 of the start window (host offset 2). Writing 1 while that bit already holds 1 starts nothing.
- R3: An inner write stores the write-data window (host offset 1) into the addressed inner register when the access completes.
- R4: After an inner read completes, the read-data window (host offset 3) holds the addressed inner value. Host writes to that window, and inner write accesses, leave it unchanged.
- R5: While the space is locked, inner writes to any address other than 0 leave the target register unchanged.
- R6: An inner write of 0xA5000000 to address 0 unlocks the space, and any other value written there locks it. An inner read of address 0 returns 1 in bit 0 when the space is unlocked and 0 otherwise, with all other bits 0.
- R7: `busy_o` rises on the edge that starts an access and falls on the edge that completes it, `ACCESS_LAT` edges later. A start edge that arrives while busy is high is ignored.
- R8: An inner read of address 0x26 returns `calib_i` in bits [4:0], with all other bits 0. Inner writes to 0x26 have no effect on that value.
- R9: Reset clears every window register and every inner register, deasserts busy and leaves the space locked.
- R10: The address, direction and data used by an access are the window contents at the start edge. Host writes to the windows during busy do not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Host write strobe |
| addr_i | input | 2 | Host window select |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data of the selected window (combinational) |
| busy_o | output | 1 | Inner access in progress |
| calib_i | input | 5 | Calibration code shown at inner address 0x26 |

## Verification
Two functions can fall in the same cycle: host window writes and the completion of an inner access. The bench provokes this by writing new data and a new control word in the busy cycles, including the completing edge, and then checks that the inner result reflects only the values present at the start edge. A second overlap is a fresh start edge, produced by writing 0 and then 1 to the start bit, that lands in the cycle where the previous access completes. That edge is judged to be ignored when busy stays low afterwards.

// File: rtl/dllw_pkg.sv
package dllw_pkg;
  localparam int HOST_DW   = 32;
  localparam int INNER_AW  = 6;
  localparam int INNER_NUM = 1 << INNER_AW;

  typedef enum logic [1:0] {
    WIN_CTRL  = 2'd0,
    WIN_WDATA = 2'd1,
    WIN_START = 2'd2,
    WIN_RDATA = 2'd3
  } win_e;

  typedef struct packed {
    logic                rd;
    logic [INNER_AW-1:0] addr;
    logic [HOST_DW-1:0]  data;
  } inner_op_t;

  localparam int CTRL_DIR_BIT = 8;
endpackage

// File: rtl/dllw_host_regs.sv
module dllw_host_regs
  import dllw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [HOST_DW-1:0] wdata_i,
  input  logic               capture_i,
  input  logic [HOST_DW-1:0] result_i,
  output logic               start_edge_o,
  output inner_op_t          win_op_o,
  output logic [HOST_DW-1:0] rdata_o
);
  logic [INNER_AW-1:0] ctrl_addr_q;
  logic                ctrl_rd_q;
  logic [HOST_DW-1:0]  wdata_q;
  logic                start_q;
  logic [HOST_DW-1:0]  rdata_q;

  logic wr_ctrl, wr_wdata, wr_start;
  assign wr_ctrl  = we_i && (win_e'(addr_i) == WIN_CTRL);
  assign wr_wdata = we_i && (win_e'(addr_i) == WIN_WDATA);
  assign wr_start = we_i && (win_e'(addr_i) == WIN_START);

  assign start_edge_o = wr_start && wdata_i[0] && !start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_addr_q <= '0;
      ctrl_rd_q   <= 1'b0;
      wdata_q     <= '0;
      start_q     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_addr_q <= wdata_i[INNER_AW-1:0];
        ctrl_rd_q   <= wdata_i[CTRL_DIR_BIT];
      end
      if (wr_wdata) wdata_q <= wdata_i;
      if (wr_start) start_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= result_i;
  end

  assign win_op_o = '{rd: ctrl_rd_q, addr: ctrl_addr_q, data: wdata_q};

  always_comb begin
    rdata_o = '0;
    unique case (win_e'(addr_i))
      WIN_CTRL: begin
        rdata_o[INNER_AW-1:0]  = ctrl_addr_q;
        rdata_o[CTRL_DIR_BIT]  = ctrl_rd_q;
      end
      WIN_WDATA: rdata_o    = wdata_q;
      WIN_START: rdata_o[0] = start_q;
      WIN_RDATA: rdata_o    = rdata_q;
      default:   rdata_o    = '0;
    endcase
  end

  // read window changes only on an inner read completion
  assert_rdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(rdata_q));
  assert_start_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_edge_o |=> start_q);
endmodule

// File: rtl/dllw_seq.sv
module dllw_seq
  import dllw_pkg::*;
#(
  parameter int ACCESS_LAT = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  inner_op_t win_op_i,
  output logic      busy_o,
  output logic      go_o,
  output inner_op_t op_o
);
  localparam int CNT_W = (ACCESS_LAT > 1) ? $clog2(ACCESS_LAT) : 1;

  logic      busy_q;
  inner_op_t op_q;
  logic      accept;

  assign accept = start_i && !busy_q;
  assign busy_o = busy_q;
  assign op_o   = op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     op_q <= '0;
    else if (accept) op_q <= win_op_i;
  end

  generate
    if (ACCESS_LAT <= 1) begin : g_single
      assign go_o = busy_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     busy_q <= 1'b0;
        else if (accept) busy_q <= 1'b1;
        else if (go_o)   busy_q <= 1'b0;
      end
    end else begin : g_multi
      logic [CNT_W-1:0] cnt_q;
      assign go_o = busy_q && (cnt_q == '0);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else if (accept) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(ACCESS_LAT - 1);
        end else if (go_o) begin
          busy_q <= 1'b0;
        end else if (busy_q) begin
          cnt_q  <= cnt_q - 1'b1;
        end
      end
      assert_no_early_go_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_q) |-> !go_o);
    end
  endgenerate

  assert_busy_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(op_q));
  assert_go_ends_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> !busy_q);
endmodule

// File: rtl/dllw_inner_array.sv
module dllw_inner_array
  import dllw_pkg::*;
#(
  parameter logic [HOST_DW-1:0]  UNLOCK_KEY  = 32'hA500_0000,
  parameter logic [INNER_AW-1:0] STATUS_ADDR = 6'h26,
  parameter int                  CALIB_W     = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  inner_op_t          op_i,
  input  logic [CALIB_W-1:0] calib_i,
  output logic [HOST_DW-1:0] rd_val_o
);
  logic [INNER_NUM-1:0][HOST_DW-1:0] mem_q;
  logic unlocked_q;
  logic wr_go, wr_key, wr_plain;

  assign wr_go    = go_i && !op_i.rd;
  assign wr_key   = wr_go && (op_i.addr == '0);
  assign wr_plain = wr_go && unlocked_q && (op_i.addr != '0) && (op_i.addr != STATUS_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     unlocked_q <= 1'b0;
    else if (wr_key) unlocked_q <= (op_i.data == UNLOCK_KEY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mem_q <= '0;
    else if (wr_plain) mem_q[op_i.addr] <= op_i.data;
  end

  always_comb begin
    rd_val_o = '0;
    if (op_i.addr == '0)              rd_val_o[0] = unlocked_q;
    else if (op_i.addr == STATUS_ADDR) rd_val_o[CALIB_W-1:0] = calib_i;
    else                               rd_val_o = mem_q[op_i.addr];
  end

  genvar gi;
  generate
    for (gi = 1; gi < INNER_NUM; gi++) begin : g_lock_chk
      assert_locked_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_go && !unlocked_q && op_i.addr == INNER_AW'(gi)) |=> $stable(mem_q[gi]));
    end
  endgenerate

  assert_unlock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && op_i.addr == '0 && op_i.data == UNLOCK_KEY) |=> unlocked_q);
  assert_relock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && op_i.addr == '0 && op_i.data != UNLOCK_KEY) |=> !unlocked_q);
endmodule

// File: rtl/dllw_port.sv
module dllw_port
  import dllw_pkg::*;
#(
  parameter int                  ACCESS_LAT  = 2,
  parameter logic [HOST_DW-1:0]  UNLOCK_KEY  = 32'hA500_0000,
  parameter logic [INNER_AW-1:0] STATUS_ADDR = 6'h26,
  parameter int                  CALIB_W     = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [HOST_DW-1:0] wdata_i,
  output logic [HOST_DW-1:0] rdata_o,
  output logic               busy_o,
  input  logic [CALIB_W-1:0] calib_i
);
  logic               start_edge;
  inner_op_t          win_op;
  inner_op_t          cur_op;
  logic               go;
  logic [HOST_DW-1:0] rd_val;

  dllw_host_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .capture_i    (go && cur_op.rd),
    .result_i     (rd_val),
    .start_edge_o (start_edge),
    .win_op_o     (win_op),
    .rdata_o      (rdata_o)
  );

  dllw_seq #(.ACCESS_LAT(ACCESS_LAT)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_edge),
    .win_op_i (win_op),
    .busy_o   (busy_o),
    .go_o     (go),
    .op_o     (cur_op)
  );

  dllw_inner_array #(
    .UNLOCK_KEY  (UNLOCK_KEY),
    .STATUS_ADDR (STATUS_ADDR),
    .CALIB_W     (CALIB_W)
  ) u_arr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .op_i     (cur_op),
    .calib_i  (calib_i),
    .rd_val_o (rd_val)
  );

  assert_start_sets_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_edge && !busy_o) |=> busy_o);
endmodule

// File: tb/dllw_port_tb_top.sv
module dllw_port_tb_top;
  localparam logic [31:0] KEY = 32'hA500_0000;
  localparam logic [5:0]  STS = 6'h26;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        busy_o;
  logic [4:0]  calib_i = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] mem_m [64];
  bit          unl_m;
  logic [31:0] rwin_m;

  always #4 clk_i = ~clk_i;

  dllw_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_o(busy_o), .calib_i(calib_i)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_inner(logic [5:0] a);
    if (a == 6'd0) return {31'd0, unl_m};
    if (a == STS)  return {27'd0, calib_i};
    return mem_m[a];
  endfunction

  function automatic void model_wr(logic [5:0] a, logic [31:0] d);
    if (a == 6'd0) unl_m = (d == KEY);
    else if (a != STS && unl_m) mem_m[a] = d;
  endfunction

  task automatic bus_wr(logic [1:0] a, logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic host_rd(logic [1:0] a, output logic [31:0] v);
    addr_i = a; #1; v = rdata_o;
  endtask

  task automatic inner_op(bit rd, logic [5:0] a, logic [31:0] d, string req);
    logic [31:0] v, e;
    bus_wr(2'd2, 32'd0);
    bus_wr(2'd0, {23'd0, rd, 2'd0, a});
    bus_wr(2'd1, d);
    bus_wr(2'd2, 32'd1);
    chk("R7 busy after start", {31'd0, busy_o}, 32'd1);
    e = exp_inner(a);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R7 busy cleared", {31'd0, busy_o}, 32'd0);
    if (rd) rwin_m = e; else model_wr(a, d);
    host_rd(2'd3, v);
    chk(req, v, rwin_m);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int seed;
    seed = $urandom(32'd7321);
    for (int i = 0; i < 64; i++) mem_m[i] = '0;
    unl_m = 1'b0; rwin_m = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 reset state
    for (int w = 0; w < 4; w++) begin
      host_rd(w[1:0], v);
      chk("R9 window reset", v, 32'd0);
    end
    chk("R9 busy reset", {31'd0, busy_o}, 32'd0);
    inner_op(1'b1, 6'd0, 32'd0, "R9 R6 locked after reset");
    inner_op(1'b1, 6'd17, 32'd0, "R9 inner reg reset");

    // R1 control masking
    bus_wr(2'd0, 32'hFFFF_FFFF);
    host_rd(2'd0, v);
    chk("R1 ctrl mask", v, 32'h0000_013F);
    bus_wr(2'd1, 32'hDEAD_BEEF);
    host_rd(2'd1, v);
    chk("R3 wdata window", v, 32'hDEAD_BEEF);

    // R4 read window is not host writable
    bus_wr(2'd3, 32'h5555_AAAA);
    host_rd(2'd3, v);
    chk("R4 rdata window write ignored", v, rwin_m);

    // R5 locked drop
    inner_op(1'b0, 6'd5, 32'h0000_1234, "R4 rdata unchanged by write");
    inner_op(1'b1, 6'd5, 32'd0, "R5 locked write dropped");

    // R6 wrong key, right key, write, relock
    inner_op(1'b0, 6'd0, 32'h1234_5678, "R4 rdata unchanged by write");
    inner_op(1'b1, 6'd0, 32'd0, "R6 wrong key keeps lock");
    inner_op(1'b0, 6'd0, KEY, "R4 rdata unchanged by write");
    inner_op(1'b1, 6'd0, 32'd0, "R6 unlocked flag");
    inner_op(1'b0, 6'd5, 32'hCAFE_0005, "R3 write");
    inner_op(1'b1, 6'd5, 32'd0, "R3 R4 readback");
    inner_op(1'b0, 6'd63, 32'h8000_0001, "R3 write top");
    inner_op(1'b1, 6'd63, 32'd0, "R3 R4 readback top");
    inner_op(1'b0, 6'd0, 32'hA500_0001, "R4 rdata unchanged by write");
    inner_op(1'b0, 6'd5, 32'h1111_1111, "R4 rdata unchanged by write");
    inner_op(1'b1, 6'd5, 32'd0, "R6 relock drops write");
    inner_op(1'b0, 6'd0, KEY, "R4 rdata unchanged by write");

    // R8 status
    calib_i = 5'h15;
    inner_op(1'b1, STS, 32'd0, "R8 status read");
    inner_op(1'b0, STS, 32'hFFFF_FFFF, "R4 rdata unchanged by write");
    calib_i = 5'h0A;
    inner_op(1'b1, STS, 32'd0, "R8 status after write");

    // R2 no start without a low level first
    inner_op(1'b1, 6'd5, 32'd0, "R2 setup read");
    bus_wr(2'd0, {23'd0, 1'b1, 2'd0, STS});
    bus_wr(2'd2, 32'd1);
    chk("R2 no busy without edge", {31'd0, busy_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    host_rd(2'd3, v);
    chk("R2 rdata unchanged without edge", v, rwin_m);

    // R7 start edge during busy ignored (lands on completion edge)
    bus_wr(2'd2, 32'd0);
    bus_wr(2'd0, {23'd0, 1'b0, 2'd0, 6'd9});
    bus_wr(2'd1, 32'h0909_0909);
    we_i = 1'b1; addr_i = 2'd2; wdata_i = 32'd1;
    @(negedge clk_i);
    wdata_i = 32'd0;
    @(negedge clk_i);
    wdata_i = 32'd1;
    @(negedge clk_i);
    we_i = 1'b0;
    chk("R7 start during busy ignored", {31'd0, busy_o}, 32'd0);
    model_wr(6'd9, 32'h0909_0909);
    inner_op(1'b1, 6'd9, 32'd0, "R7 single write done");

    // R10 window changes during busy do not alter the access
    bus_wr(2'd2, 32'd0);
    bus_wr(2'd0, {23'd0, 1'b0, 2'd0, 6'd10});
    bus_wr(2'd1, 32'h0A0A_0A0A);
    we_i = 1'b1; addr_i = 2'd2; wdata_i = 32'd1;
    @(negedge clk_i);
    addr_i = 2'd1; wdata_i = 32'hBBBB_BBBB;
    @(negedge clk_i);
    addr_i = 2'd0; wdata_i = {23'd0, 1'b1, 2'd0, 6'd11};
    @(negedge clk_i);
    we_i = 1'b0;
    model_wr(6'd10, 32'h0A0A_0A0A);
    inner_op(1'b1, 6'd10, 32'd0, "R10 captured data used");
    inner_op(1'b1, 6'd11, 32'd0, "R10 other reg untouched");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      bit rd;
      logic [5:0] a;
      logic [31:0] d;
      int sel;
      rd  = $urandom_range(0, 1) == 1;
      sel = $urandom_range(0, 7);
      a   = (sel == 0) ? 6'd0 : (sel == 1) ? STS : 6'($urandom_range(0, 63));
      d   = (a == 6'd0 && $urandom_range(0, 2) != 0) ? KEY : $urandom;
      calib_i = 5'($urandom_range(0, 31));
      inner_op(rd, a, d, rd ? "R3 R4 R5 R6 R8 random read" : "R4 random write");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule